// File: doc/BRIEF.md
# Two-Stage Audio Clock Divider

This block derives two audio bit-rate timing streams from one of three reference-rate tick sources. A single 32-bit configuration word picks the source, a divisor code for the codec master clock (MCLK) and a divisor code for the serial bit clock (SCLK). It also carries a flag that allows the SCLK outputs to be driven. The first stage counts ticks of the selected source and produces the MCLK tick strobe and level. The second stage counts MCLK ticks, not source ticks, and produces the SCLK tick strobe and level.

Every input and output sits in one reference clock domain. The outputs are single-cycle clock-enable strobes and gated levels, not derived clocks. The configuration word may change at any moment. Each stage takes up a new setting only when its current period ends, so no period is ever cut short or stretched.

Top module: `audio_clkdiv_top`

## Requirements
- R1: Bits 31:30 of `cfg_word` pick the source. Value 0 selects `src_tick[0]`, value 1 selects `src_tick[1]` and value 2 selects `src_tick[2]`. An MCLK tick is only ever produced in a cycle in which the selected source strobe is high.
- R2: The MCLK divisor code sits in bits 28:24. Four codes are special: 0x14 divides by 1, 0x13 by 3, 0x12 by 5 and 0x0E by 14. A divisor of N gives exactly one MCLK tick per N selected-source ticks.
- R3: Every other MCLK code c gives the even divisor 2*(c+1). For example, code 2 divides by 6.
- R4: The SCLK divisor code sits in bits 23:20 and counts MCLK ticks. Code 8 divides by 1, code 9 divides by 3, and every other code c divides by 2*(c+1). An SCLK tick only ever falls in a cycle that also carries an MCLK tick.
- R5: Bit 19 is the master flag. While it is clear, `sclk_tick` and `sclk_lvl` stay low.
- R6: Source value 3 stops both stages. While it is in effect, all four outputs stay low.
- R7: For a divisor N the level is high for ceil(N/2) input ticks and low for the rest of the period. The level rises only in the cycle after that stage's output tick.
- R8: With a divisor of 1, the stage's output tick equals its input tick in the same cycle, and its level stays high.
- R9: A change to the source, a divisor or the master flag takes effect in a stage only on the input tick that ends that stage's current period. The period in progress keeps its full length and its full high time.
- R10: While `rst` is high (synchronous, active high), all outputs are low. Both counters restart from zero once `rst` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Configuration word: source, MCLK code, SCLK code, master flag |
| src_tick | input | 3 | One tick strobe per source |
| mclk_tick | output | 1 | MCLK clock-enable strobe |
| mclk_lvl | output | 1 | MCLK level |
| sclk_tick | output | 1 | SCLK clock-enable strobe |
| sclk_lvl | output | 1 | SCLK level |

## Verification
Two functions can land in the same cycle. One is a change of the configuration word arriving on the very tick that ends a period. The other is a period boundary in both stages at once, when an SCLK tick rides on an MCLK tick. The bench rewrites the configuration at arbitrary phases, and once on the tick that opens a long MCLK period. It judges every cycle against a behavioural model that applies the new setting only at each stage's own terminal tick. It also measures the high run of the interrupted period and expects the old length.

// File: rtl/acd_pkg.sv
package acd_pkg;

    localparam int NSRC  = 3;
    localparam int CNT_W = 7;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_LOW  = 2'd0,
        SRC_MID  = 2'd1,
        SRC_HIGH = 2'd2,
        SRC_OFF  = 2'd3
    } src_sel_e;

    typedef struct packed {
        src_sel_e    src;
        logic [4:0]  mcode;
        logic [3:0]  scode;
        logic        master;
    } clk_cfg_t;

    function automatic clk_cfg_t unpack_cfg(input logic [31:0] w);
        clk_cfg_t c;
        c.src    = src_sel_e'(w[31:30]);
        c.mcode  = w[28:24];
        c.scode  = w[23:20];
        c.master = w[19];
        return c;
    endfunction

    // MCLK ratio: four reserved odd/special codes, else 2*(code+1)
    function automatic logic [CNT_W-1:0] mclk_ratio(input logic [4:0] code);
        case (code)
            5'h14:   return CNT_W'(1);
            5'h13:   return CNT_W'(3);
            5'h12:   return CNT_W'(5);
            5'h0E:   return CNT_W'(14);
            default: return (CNT_W'(code) + CNT_W'(1)) << 1;
        endcase
    endfunction

    // SCLK ratio: two special codes, else 2*(code+1)
    function automatic logic [CNT_W-1:0] sclk_ratio(input logic [3:0] code);
        case (code)
            4'h8:    return CNT_W'(1);
            4'h9:    return CNT_W'(3);
            default: return (CNT_W'(code) + CNT_W'(1)) << 1;
        endcase
    endfunction

endpackage

// File: rtl/acd_src_mux.sv
module acd_src_mux #(
    parameter int N     = 3,
    parameter int SEL_W = 2
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [N-1:0]     ticks,
    output logic             tick
);
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (sel == SEL_W'(i)) tick = ticks[i];
        end
    end
endmodule

// File: rtl/acd_stage.sv
module acd_stage #(
    parameter int CW = 7,
    parameter int AW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          in_tick,
    input  logic [CW-1:0] div_new,
    input  logic [AW-1:0] aux_new,
    output logic          out_tick,
    output logic          lvl,
    output logic [AW-1:0] aux_cur
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] div_q;
    logic [CW-1:0] half;
    logic          lvl_q;
    logic          at_term;

    assign half    = CW'((div_q + CW'(1)) >> 1);
    assign at_term = (cnt_q == div_q - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            lvl_q   <= 1'b0;
            div_q   <= div_new;
            aux_cur <= aux_new;
        end else if (!en) begin
            cnt_q   <= '0;
            lvl_q   <= 1'b0;
            div_q   <= div_new;
            aux_cur <= aux_new;
        end else if (in_tick) begin
            lvl_q <= (cnt_q < half);
            if (at_term) begin
                cnt_q   <= '0;
                div_q   <= div_new;
                aux_cur <= aux_new;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign out_tick = en && in_tick && (cnt_q == '0) && !rst;
    assign lvl      = lvl_q && en;
endmodule

// File: rtl/audio_clkdiv_top.sv
module audio_clkdiv_top
    import acd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] cfg_word,
    input  logic [2:0]  src_tick,
    output logic        mclk_tick,
    output logic        mclk_lvl,
    output logic        sclk_tick,
    output logic        sclk_lvl
);
    clk_cfg_t         cfg;
    logic [SEL_W-1:0] sel_cur;
    logic             m_en;
    logic             m_in;
    logic             s_master_cur;
    logic             s_en;
    logic             unused_cfg_bits;

    assign cfg             = unpack_cfg(cfg_word);
    assign unused_cfg_bits = ^{cfg_word[29], cfg_word[18:0]};

    assign m_en = (sel_cur != SRC_OFF);
    assign s_en = m_en && s_master_cur;

    acd_src_mux #(.N(NSRC), .SEL_W(SEL_W)) u_mux (
        .sel   (sel_cur),
        .ticks (src_tick),
        .tick  (m_in)
    );

    acd_stage #(.CW(CNT_W), .AW(SEL_W)) u_mstage (
        .clk      (clk),
        .rst      (rst),
        .en       (m_en),
        .in_tick  (m_in),
        .div_new  (mclk_ratio(cfg.mcode)),
        .aux_new  (cfg.src),
        .out_tick (mclk_tick),
        .lvl      (mclk_lvl),
        .aux_cur  (sel_cur)
    );

    acd_stage #(.CW(CNT_W), .AW(1)) u_sstage (
        .clk      (clk),
        .rst      (rst),
        .en       (s_en),
        .in_tick  (mclk_tick),
        .div_new  (sclk_ratio(cfg.scode)),
        .aux_new  (cfg.master),
        .out_tick (sclk_tick),
        .lvl      (sclk_lvl),
        .aux_cur  (s_master_cur)
    );
endmodule

// File: rtl/acd_chk.sv
module acd_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] src_tick,
    input logic       mclk_tick,
    input logic       mclk_lvl,
    input logic       sclk_tick,
    input logic       sclk_lvl
);
    // R10
    reset_levels_low_chk: assert property (@(posedge clk)
        rst |=> (!mclk_lvl && !sclk_lvl));

    // R1
    mclk_needs_source_chk: assert property (@(posedge clk) disable iff (rst)
        mclk_tick |-> (src_tick != 3'b000));

    // R4
    sclk_on_mclk_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_tick |-> mclk_tick);

    // R7
    mclk_rise_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mclk_lvl) |-> $past(mclk_tick));

    // R7
    sclk_rise_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_lvl) |-> $past(sclk_tick));
endmodule

bind audio_clkdiv_top acd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_tick  (src_tick),
    .mclk_tick (mclk_tick),
    .mclk_lvl  (mclk_lvl),
    .sclk_tick (sclk_tick),
    .sclk_lvl  (sclk_lvl)
);

// File: tb/audio_clkdiv_top_tb.sv
`timescale 1ns/1ps
module audio_clkdiv_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = 32'h0;
    logic [2:0]  src_tick = 3'b000;
    logic        mclk_tick, mclk_lvl, sclk_tick, sclk_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R10";

    always #2.5 clk = ~clk;

    audio_clkdiv_top u_dut (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .src_tick(src_tick),
        .mclk_tick(mclk_tick), .mclk_lvl(mclk_lvl),
        .sclk_tick(sclk_tick), .sclk_lvl(sclk_lvl)
    );

    function automatic logic [31:0] mk(input int sel, input int mc, input int sc, input int ms);
        mk = {sel[1:0], 1'b0, mc[4:0], sc[3:0], ms[0], 19'h0};
    endfunction

    function automatic int mdec(input int c);
        if (c == 20) return 1;
        if (c == 19) return 3;
        if (c == 18) return 5;
        if (c == 14) return 14;
        return 2 * (c + 1);
    endfunction

    function automatic int sdec(input int c);
        if (c == 8) return 1;
        if (c == 9) return 3;
        return 2 * (c + 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // source strobes: [2] every cycle, [1] every 2nd, [0] every 4th
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk); #1;
            ph++;
            src_tick = {1'b1, ph[0], (ph[1:0] == 2'b00)};
        end
    end

    // behavioural reference, updated at each edge
    int mc = 0, md = 1, ma = 0, ml = 0;
    int sc = 0, sd = 1, sa = 0, sl = 0;

    always @(posedge clk) begin
        int cw;
        bit men, min, mt, sen;
        cw = int'(cfg_word);
        if (rst) begin
            mc = 0; ml = 0; md = mdec(cw >> 24 & 31); ma = cw >>> 30 & 3;
            sc = 0; sl = 0; sd = sdec(cw >> 20 & 15); sa = cw >> 19 & 1;
        end else begin
            men = (ma != 3);
            min = men && src_tick[ma];
            mt  = min && (mc == 0);
            sen = men && (sa == 1);
            if (!men) begin
                mc = 0; ml = 0; md = mdec(cw >> 24 & 31); ma = cw >>> 30 & 3;
            end else if (min) begin
                ml = (mc < (md + 1) / 2) ? 1 : 0;
                if (mc == md - 1) begin
                    mc = 0; md = mdec(cw >> 24 & 31); ma = cw >>> 30 & 3;
                end else mc++;
            end
            if (!sen) begin
                sc = 0; sl = 0; sd = sdec(cw >> 20 & 15); sa = cw >> 19 & 1;
            end else if (mt) begin
                sl = (sc < (sd + 1) / 2) ? 1 : 0;
                if (sc == sd - 1) begin
                    sc = 0; sd = sdec(cw >> 20 & 15); sa = cw >> 19 & 1;
                end else sc++;
            end
        end
    end

    // per-cycle comparison against the model (R9 and the current phase tag)
    always @(negedge clk) begin
        bit men, emt, sen;
        if (!rst && !done) begin
            men = (ma != 3);
            emt = men && src_tick[ma] && (mc == 0);
            sen = men && (sa == 1);
            check({tag, "/R9 mclk_tick"}, int'(mclk_tick), int'(emt));
            check({tag, "/R9 mclk_lvl"},  int'(mclk_lvl),  (men && ml == 1) ? 1 : 0);
            check({tag, "/R9 sclk_tick"}, int'(sclk_tick), (sen && emt && sc == 0) ? 1 : 0);
            check({tag, "/R9 sclk_lvl"},  int'(sclk_lvl),  (sen && sl == 1) ? 1 : 0);
        end
    end

    int n_mt, n_mh, n_st, n_sh;
    task automatic measure(input int n);
        n_mt = 0; n_mh = 0; n_st = 0; n_sh = 0;
        repeat (n) begin
            @(negedge clk);
            n_mt += int'(mclk_tick); n_mh += int'(mclk_lvl);
            n_st += int'(sclk_tick); n_sh += int'(sclk_lvl);
        end
    endtask

    task automatic setcfg(input logic [31:0] w);
        @(posedge clk); #1;
        cfg_word = w;
        repeat (200) @(posedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #500000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int run;
        cfg_word = mk(2, 19, 8, 1);
        repeat (3) @(negedge clk);
        // R10: outputs low during reset
        check("R10 reset mclk_tick", int'(mclk_tick), 0);
        check("R10 reset mclk_lvl", int'(mclk_lvl), 0);
        check("R10 reset sclk_lvl", int'(sclk_lvl), 0);
        @(posedge clk); #1; rst = 0;
        repeat (100) @(posedge clk);

        // R2/R7/R8: mclk /3 from source 2, sclk /1
        tag = "R2";
        measure(30);
        check("R2 mclk div3 ticks", n_mt, 10);
        check("R7 mclk div3 high", n_mh, 20);
        check("R8 sclk div1 ticks", n_st, 10);
        check("R8 sclk div1 level", n_sh, 30);

        // R2/R7: mclk /14
        setcfg(mk(2, 14, 8, 1));
        measure(28);
        check("R2 mclk div14 ticks", n_mt, 2);
        check("R7 mclk div14 high", n_mh, 14);

        // R3/R4: mclk code 2 -> /6, sclk code 9 -> /3
        tag = "R3";
        setcfg(mk(2, 2, 9, 1));
        measure(36);
        check("R3 mclk div6 ticks", n_mt, 6);
        check("R3 mclk div6 high", n_mh, 18);
        check("R4 sclk div3 ticks", n_st, 2);
        check("R7 sclk div3 high", n_sh, 24);

        // R1/R8: source 1, mclk /1, sclk code 0 -> /2
        tag = "R1";
        setcfg(mk(1, 20, 0, 1));
        measure(40);
        check("R1 mclk from source 1 ticks", n_mt, 20);
        check("R8 mclk div1 level", n_mh, 40);
        check("R4 sclk div2 ticks", n_st, 10);
        check("R7 sclk div2 high", n_sh, 20);

        // R1: source 0 (every 4th cycle), mclk /1
        setcfg(mk(0, 20, 0, 1));
        measure(40);
        check("R1 mclk from source 0 ticks", n_mt, 10);

        // R5: master flag clear
        tag = "R5";
        setcfg(mk(1, 20, 0, 0));
        measure(40);
        check("R5 sclk ticks with master clear", n_st, 0);
        check("R5 sclk level with master clear", n_sh, 0);
        check("R5 mclk unaffected", n_mt, 20);

        // R6: reserved source stops everything
        tag = "R6";
        setcfg(mk(3, 20, 0, 1));
        measure(40);
        check("R6 mclk ticks stopped", n_mt, 0);
        check("R6 mclk level low", n_mh, 0);
        check("R6 sclk ticks stopped", n_st, 0);
        check("R6 sclk level low", n_sh, 0);

        // R9: change /14 -> /2 on the tick that opens a period
        tag = "R9";
        setcfg(mk(2, 14, 8, 1));
        @(negedge clk);
        while (!mclk_tick) @(negedge clk);
        @(posedge clk); #1;
        cfg_word = mk(2, 0, 8, 1);
        run = 0;
        @(negedge clk);
        while (mclk_lvl) begin run++; @(negedge clk); end
        check("R9 interrupted period keeps high run", run, 7);
        repeat (40) @(posedge clk);
        measure(20);
        check("R9 new divisor /2 in force", n_mt, 10);

        // R10: mid-run reset
        tag = "R10";
        @(posedge clk); #1; rst = 1;
        @(negedge clk);
        check("R10 mid-run mclk_lvl", int'(mclk_lvl), 0);
        check("R10 mid-run mclk_tick", int'(mclk_tick), 0);
        check("R10 mid-run sclk_tick", int'(sclk_tick), 0);
        @(posedge clk); #1; rst = 0;
        repeat (30) @(posedge clk);
        finish_run();
    end
endmodule